// File: doc/BRIEF.md
# Masked fast GPIO port

This block is a 32-pin general-purpose I/O port with a register interface. Software sets pin directions, drives output levels through a direct pin register or through set and clear registers, and reads pin levels after a two-stage synchronizer. A per-pin mask register protects chosen pins. While a pin's mask bit is 1, writes to the set, clear and pin registers leave that pin's output latch unchanged, and a read of the pin register returns 0 in that position.

Every register is written through byte enables, so byte, half-word and word accesses all work the same way. This matters most for the mask. Software can protect or release one byte lane or one half of the port without a read-modify-write sequence.

The request channel uses valid/ready. `req_ready` is always high, so a request is taken on every clock edge where `req_valid` is high. There is no back-pressure. A read produces exactly one response beat, with `rsp_valid` high, on the cycle after the request is taken. The response channel has no ready signal, so the requester must accept that beat. A write produces no response.

Top module: `gpio_mask_port`

## Requirements
- R1: `req_ready` is always 1. A read request taken at a clock edge gives `rsp_valid`=1 and the read data during the next cycle. A write gives no response beat.
- R2: The register word offsets (byte address, with `req_addr[1:0]` ignored) are: direction 0x00, mask 0x04, pin 0x08, set 0x0C, clear 0x10. Set, clear and unused offsets (0x14 to 0x1C) read as 0, and writes to unused offsets change nothing.
- R3: Enable bit k of `req_be` selects data bits 8k+7..8k, which are pins 8k..8k+7. A mask write changes only the enabled lanes. The enables 0xF, 0x3, 0xC and one-hot values give the word, lower half, upper half and single-byte accesses.
- R4: After reset the direction, mask and output latch are all 0, so `pad_oe`=0 and `pad_out`=0.
- R5: For each enabled, unmasked bit written as 1 to the set register, the output latch bit becomes 1. Bits written as 0 do not change.
- R6: For each enabled, unmasked bit written as 1 to the clear register, the output latch bit becomes 0. Bits written as 0 do not change.
- R7: A write to the pin register loads each enabled, unmasked output latch bit with the written value.
- R8: While a mask bit is 1, writes to the set, clear and pin registers leave that bit of the output latch unchanged.
- R9: A pin register read returns the synchronized pad level for bits whose mask is 0, and 0 for bits whose mask is 1.
- R10: A `pad_in` change made between edges n-1 and n is not seen by reads taken at edges n and n+1. It is seen by a read taken at edge n+2.
- R11: `pad_oe` equals the direction register and `pad_out` equals the output latch. Both update on the edge where the write is taken.
- R12: A direction write changes only the enabled byte lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken (always 1) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address |
| req_be | input | 4 | Byte lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data beat |
| rsp_data | output | 32 | Read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Output latch towards the pads |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
The assertions assume that `rst_n` is held low until the first rising clock edge, and that the requester never needs to stall a response beat, since the response channel has no ready signal. They also assume that `pad_in` settles in the cycles between the point where it changes and the point where a read samples it. The stimulus drives all bus inputs at falling edges and, after each random change to `pad_in`, waits three cycles before reading the pin register. It only changes `pad_in` near a read in the directed latency case, where the timing of the change is the thing under test.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned WORD_DIR  = 0;
  localparam int unsigned WORD_MASK = 1;
  localparam int unsigned WORD_PIN  = 2;
  localparam int unsigned WORD_SET  = 3;
  localparam int unsigned WORD_CLR  = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_MASK,
    SEL_PIN,
    SEL_SET,
    SEL_CLR
  } reg_sel_e;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_mask_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5,
  localparam int NBYTES = WIDTH / 8
) (
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NBYTES-1:0] req_be,
  output reg_sel_e          sel,
  output logic              wr_en,
  output logic              rd_en,
  output logic [WIDTH-1:0]  lane_bits
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             unused_low;

  assign word_idx   = req_addr[ADDR_W-1:2];
  assign unused_low = ^req_addr[1:0];
  assign wr_en      = req_valid && req_wr;
  assign rd_en      = req_valid && !req_wr;

  always_comb begin
    sel = SEL_NONE;
    if (32'(word_idx) == WORD_DIR)       sel = SEL_DIR;
    else if (32'(word_idx) == WORD_MASK) sel = SEL_MASK;
    else if (32'(word_idx) == WORD_PIN)  sel = SEL_PIN;
    else if (32'(word_idx) == WORD_SET)  sel = SEL_SET;
    else if (32'(word_idx) == WORD_CLR)  sel = SEL_CLR;
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign lane_bits[8*k +: 8] = {8{req_be[k]}};
  end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_mask_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] lane_bits,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] out_q
);
  logic [WIDTH-1:0] open_bits;
  logic [WIDTH-1:0] hit_bits;
  logic [WIDTH-1:0] dir_next;
  logic [WIDTH-1:0] mask_next;
  logic [WIDTH-1:0] out_next;

  // Pins whose lane is enabled and whose mask bit is clear
  assign open_bits = lane_bits & ~mask_q;
  assign hit_bits  = wdata & open_bits;

  always_comb begin
    dir_next  = dir_q;
    mask_next = mask_q;
    out_next  = out_q;
    if (wr_en) begin
      case (sel)
        SEL_DIR:  dir_next  = (dir_q & ~lane_bits) | (wdata & lane_bits);
        SEL_MASK: mask_next = (mask_q & ~lane_bits) | (wdata & lane_bits);
        SEL_PIN:  out_next  = (out_q & ~open_bits) | hit_bits;
        SEL_SET:  out_next  = out_q | hit_bits;
        SEL_CLR:  out_next  = out_q & ~hit_bits;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else begin
      dir_q  <= dir_next;
      mask_q <= mask_next;
      out_q  <= out_next;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] sync_q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= pad_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int NBYTES = WIDTH / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NBYTES-1:0] req_be,
  input  logic [WIDTH-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [WIDTH-1:0]  rsp_data,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  reg_sel_e         sel;
  logic             wr_en;
  logic             rd_en;
  logic [WIDTH-1:0] lane_bits;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] rd_word;

  assign req_ready = 1'b1;

  gpio_reg_decode #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_decode (
    .req_valid (req_valid),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .sel       (sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .lane_bits (lane_bits)
  );

  gpio_out_regs #(.WIDTH(WIDTH)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .sel       (sel),
    .lane_bits (lane_bits),
    .wdata     (req_wdata),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .out_q     (out_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .sync_q (sync_q)
  );

  always_comb begin
    case (sel)
      SEL_DIR:  rd_word = dir_q;
      SEL_MASK: rd_word = mask_q;
      SEL_PIN:  rd_word = sync_q & ~mask_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_word;
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk
  import gpio_mask_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [WIDTH-1:0]  rsp_data,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  mask_q
);
  logic pin_rd;
  assign pin_rd = req_valid && !req_wr && (32'(req_addr[ADDR_W-1:2]) == WORD_PIN);

  p_rsp_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_wr) |-> rsp_valid);

  p_no_rsp_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_wr) |-> !rsp_valid);

  p_reset_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask_q == '0 && pad_oe == '0 && pad_out == '0));

  p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((pad_out ^ $past(pad_out)) & $past(mask_q)) == '0));

  p_masked_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_rd) |-> ((rsp_data & $past(mask_q)) == '0));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(req_valid && req_wr)) |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_mask_port gpio_mask_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_wr    (req_wr),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .mask_q    (mask_q)
);

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  localparam logic [4:0] A_DIR = 5'h00, A_MASK = 5'h04, A_PIN = 5'h08,
                         A_SET = 5'h0C, A_CLR = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_wr = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [31:0] m_dir = '0, m_mask = '0, m_out = '0;

  always #4 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = {8{be[k]}};
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a[4:2])
      3'd0:    return m_dir;
      3'd1:    return m_mask;
      3'd2:    return pad_in & ~m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] l, open;
    l = lanes(be);
    open = l & ~m_mask;
    case (a[4:2])
      3'd0: m_dir  = (m_dir & ~l) | (d & l);
      3'd1: m_mask = (m_mask & ~l) | (d & l);
      3'd2: m_out  = (m_out & ~open) | (d & open);
      3'd3: m_out  = m_out | (d & open);
      3'd4: m_out  = m_out & ~(d & open);
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    req_valid = 1'b1; req_wr = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wr = 1'b0;
    model_write(a, be, d);
    chk("R1 no rsp on write", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = a; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_data;
  endtask

  task automatic chk_ports(input string tag);
    chk({tag, " pad_out"}, pad_out, m_out);
    chk({tag, " pad_oe"}, pad_oe, m_dir);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  be_set [7] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF};
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk("R4 pad_out reset", pad_out, 32'h0);
    chk("R4 pad_oe reset", pad_oe, 32'h0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    bus_rd(A_MASK, rd); chk("R4 mask reset", rd, 32'h0);
    bus_rd(A_DIR, rd);  chk("R4 dir reset", rd, 32'h0);

    // R3 lane-wise mask writes
    bus_wr(A_MASK, 4'h4, 32'hA5A5A5A5);
    bus_rd(A_MASK, rd); chk("R3 byte lane 2", rd, 32'h00A50000);
    bus_wr(A_MASK, 4'h3, 32'h12341234);
    bus_rd(A_MASK, rd); chk("R3 lower half", rd, 32'h00A51234);
    bus_wr(A_MASK, 4'hC, 32'hBEEF0000);
    bus_rd(A_MASK, rd); chk("R3 upper half", rd, 32'hBEEF1234);
    bus_wr(A_MASK, 4'hF, 32'h0);
    bus_rd(A_MASK, rd); chk("R3 word clear", rd, 32'h0);

    // R12 direction lanes, R11 pad_oe
    bus_wr(A_DIR, 4'h2, 32'hFFFFFFFF);
    chk("R12 dir byte lane 1", pad_oe, 32'h0000FF00);
    bus_wr(A_DIR, 4'hF, 32'hFFFFFFFF);
    chk_ports("R11 dir word");

    // R5/R6/R7 unmasked
    bus_wr(A_SET, 4'hF, 32'h0000F00F); chk_ports("R5 set");
    bus_wr(A_CLR, 4'hF, 32'h00000003); chk_ports("R6 clear");
    bus_wr(A_PIN, 4'h1, 32'h5A5A5A5A); chk_ports("R7 pin byte");

    // R8 fully masked
    bus_wr(A_MASK, 4'hF, 32'hFFFFFFFF);
    bus_wr(A_SET, 4'hF, 32'hFFFFFFFF); chk("R8 set masked", pad_out, m_out);
    bus_wr(A_CLR, 4'hF, 32'hFFFFFFFF); chk("R8 clr masked", pad_out, m_out);
    bus_wr(A_PIN, 4'hF, 32'h0);        chk("R8 pin masked", pad_out, m_out);

    // R9 masked read
    pad_in = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    bus_rd(A_PIN, rd); chk("R9 all masked read", rd, 32'h0);
    bus_wr(A_MASK, 4'h5, 32'h0);
    bus_rd(A_PIN, rd); chk("R9 partial mask read", rd, 32'h00FF00FF);

    // R2 set/clr/unused read zero, unused write ignored
    bus_rd(A_SET, rd); chk("R2 set reads 0", rd, 32'h0);
    bus_rd(A_CLR, rd); chk("R2 clr reads 0", rd, 32'h0);
    bus_wr(5'h18, 4'hF, 32'hFFFFFFFF); chk_ports("R2 unused write");
    bus_rd(5'h1C, rd); chk("R2 unused read", rd, 32'h0);

    // R10 synchronizer latency
    bus_wr(A_MASK, 4'hF, 32'h0);
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    pad_in = 32'h13572468;
    bus_rd(A_PIN, rd); chk("R10 edge n old", rd, 32'h0);
    bus_rd(A_PIN, rd); chk("R10 edge n+1 old", rd, 32'h0);
    bus_rd(A_PIN, rd); chk("R10 edge n+2 new", rd, 32'h13572468);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      logic [4:0]  a;
      logic [3:0]  be;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      a  = 5'($urandom_range(0, 7) << 2);
      be = be_set[$urandom_range(0, 6)];
      d  = $urandom();
      if (op < 6) begin
        bus_wr(a, be, d);
        chk_ports("R5 R6 R7 R8 R12 random write");
      end else if (op < 9) begin
        bus_rd(a, rd);
        chk("R2 R9 random read", rd, exp_read(a));
      end else begin
        pad_in = $urandom();
        repeat (3) @(negedge clk);
        bus_rd(A_PIN, rd);
        chk("R9 R10 random pad", rd, pad_in & ~m_mask);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule